// File: doc/BRIEF.md
# Two-Input Fair Routing Stage

This block moves 32-bit words from two input queues to two output queues. Each cycle it looks at the head word of each input. A head word with its top bit set cannot be routed. It is popped at once, thrown away, and added to a saturating discard count. A head word with its top bit clear is sent to the output queue chosen by its bit 0.

Only one routable word moves per cycle, because both inputs might want the same output. When both inputs offer a routable word that can move, a one-bit last-served pointer gives the turn to the input that did not win last time.

All six queue ends use a valid/ready handshake. A word is taken from an input in a cycle where both its valid and its ready are high. Each output has a single holding register that acts as a one-entry skid buffer. A word is pushed into an output only when that register is empty or is being drained in the same cycle. Because of this, nothing in the block ever has to stall part-way through a transfer.

Top module: `fair_route_stage`

## Requirements
- R1: During reset and in the first cycle after it, both output valids are 0 and `drop_count` is 0.
- R2: An input head word with bit 31 = 1 is accepted in the same cycle (its ready is 1 whatever the outputs do). It never appears on any output, and `drop_count` rises by 1 at the next clock edge.
- R3: A word with bit 31 = 0 is delivered unchanged. It goes to output 0 when bit 0 = 0 and to output 1 when bit 0 = 1. It shows on that output in the cycle after it is accepted, and words reach each output in the order they were accepted.
- R4: When both input heads have bit 31 = 1 in the same cycle, both are accepted in that cycle and `drop_count` rises by 2.
- R5: `drop_count` saturates at 2^CNT_W - 1 and then stays there.
- R6: At most one routable word is accepted per cycle. When both inputs offer one in the first contended cycle after reset, input 1 wins.
- R7: Under continued contention, the winner alternates between the two inputs, cycle after cycle.
- R8: A routable word is not accepted while its target output holds a word that is not being taken (valid = 1, ready = 0). Throughout such a stall the held output word stays valid and unchanged.
- R9: Discarding a word on one input does not depend on output space, so it can happen while a routable word on the other input waits for a stalled output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_valid | input | 1 | Input 0 head present |
| in0_data | input | DATA_W | Input 0 head word |
| in0_ready | output | 1 | Input 0 head is consumed this cycle |
| in1_valid | input | 1 | Input 1 head present |
| in1_data | input | DATA_W | Input 1 head word |
| in1_ready | output | 1 | Input 1 head is consumed this cycle |
| out0_valid | output | 1 | Output 0 holds a word |
| out0_data | output | DATA_W | Output 0 word |
| out0_ready | input | 1 | Downstream takes output 0 word |
| out1_valid | output | 1 | Output 1 holds a word |
| out1_data | output | DATA_W | Output 1 word |
| out1_ready | input | 1 | Downstream takes output 1 word |
| drop_count | output | CNT_W | Saturating count of discarded words |

## Verification
The bench keeps DATA_W at 32 and sets CNT_W to 4. The discard count then tops out at 15, so a short run of paired discards can push it into saturation and test the hold at the maximum. At the default width of 32, saturation would be out of reach. With the data width left at 32, the discard flag and the route bit sit exactly where the requirements place them.

// File: rtl/fair_route_stage.sv
module fair_route_stage #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in0_valid,
  input  logic [DATA_W-1:0] in0_data,
  output logic              in0_ready,
  input  logic              in1_valid,
  input  logic [DATA_W-1:0] in1_data,
  output logic              in1_ready,
  output logic              out0_valid,
  output logic [DATA_W-1:0] out0_data,
  input  logic              out0_ready,
  output logic              out1_valid,
  output logic [DATA_W-1:0] out1_data,
  input  logic              out1_ready,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int FLAG = DATA_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic last;

  wire kill0 = in0_valid & in0_data[FLAG];
  wire kill1 = in1_valid & in1_data[FLAG];

  wire room0 = ~out0_valid | out0_ready;
  wire room1 = ~out1_valid | out1_ready;

  wire cand0 = in0_valid & ~in0_data[FLAG] & (in0_data[0] ? room1 : room0);
  wire cand1 = in1_valid & ~in1_data[FLAG] & (in1_data[0] ? room1 : room0);

  wire grant1 = cand1 & (~cand0 | ~last);
  wire grant0 = cand0 & ~grant1;
  wire fire   = grant0 | grant1;

  wire [DATA_W-1:0] word = grant1 ? in1_data : in0_data;
  wire push0 = fire & ~word[0];
  wire push1 = fire & word[0];

  assign in0_ready = kill0 | grant0;
  assign in1_ready = kill1 | grant1;

  logic [1:0]     kills;
  logic [CNT_W:0] sum;
  assign kills = {1'b0, kill0} + {1'b0, kill1};
  assign sum   = {1'b0, drop_count} + (CNT_W+1)'(kills);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out0_valid <= 1'b0;
      out1_valid <= 1'b0;
      out0_data  <= '0;
      out1_data  <= '0;
      last       <= 1'b0;
      drop_count <= '0;
    end else begin
      out0_valid <= push0 | (out0_valid & ~out0_ready);
      out1_valid <= push1 | (out1_valid & ~out1_ready);
      if (push0) out0_data <= word;
      if (push1) out1_data <= word;
      if (fire)  last <= grant1;
      drop_count <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/fair_route_stage_chk.sv
module fair_route_stage_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in0_valid,
  input logic [DATA_W-1:0] in0_data,
  input logic              in0_ready,
  input logic              in1_valid,
  input logic [DATA_W-1:0] in1_data,
  input logic              in1_ready,
  input logic              out0_valid,
  input logic [DATA_W-1:0] out0_data,
  input logic              out0_ready,
  input logic              out1_valid,
  input logic [DATA_W-1:0] out1_data,
  input logic              out1_ready,
  input logic [CNT_W-1:0]  drop_count
);
  wire take0 = in0_valid & in0_ready & ~in0_data[DATA_W-1];
  wire take1 = in1_valid & in1_ready & ~in1_data[DATA_W-1];

  p_kill_pop0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in0_valid && in0_data[DATA_W-1] |-> in0_ready);
  p_kill_pop1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in1_valid && in1_data[DATA_W-1] |-> in1_ready);
  p_one_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(take0 && take1));
  p_steer0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take0 && !in0_data[0] |=> out0_valid && out0_data == $past(in0_data));
  p_hold0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out0_valid && !out0_ready |=> out0_valid && $stable(out0_data));
  p_hold1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out1_valid && !out1_ready |=> out1_valid && $stable(out1_data));
  p_cnt_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_count >= $past(drop_count));
endmodule

bind fair_route_stage fair_route_stage_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fair_route_stage.sv
module tb_fair_route_stage;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in0_valid = 0, in1_valid = 0, out0_ready = 1, out1_ready = 1;
  logic [DW-1:0] in0_data = '0, in1_data = '0;
  logic in0_ready, in1_ready, out0_valid, out1_valid;
  logic [DW-1:0] out0_data, out1_data;
  logic [CW-1:0] drop_count;

  fair_route_stage #(.DATA_W(DW), .CNT_W(CW)) dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, exp_cnt = 0;
  logic [DW-1:0] exp0[$], exp1[$];

  task automatic chk(bit ok, string tag, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic note(logic [DW-1:0] w);
    if (w[DW-1]) exp_cnt = (exp_cnt + 1 > CMAX) ? CMAX : exp_cnt + 1;
    else if (w[0]) exp1.push_back(w);
    else exp0.push_back(w);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out0_valid && out0_ready) begin
      if (exp0.size() == 0) chk(0, "R3 out0 unexpected", out0_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp0.pop_front();
        chk(out0_data == e, "R3 out0 word", out0_data, e);
      end
    end
    if (out1_valid && out1_ready) begin
      if (exp1.size() == 0) chk(0, "R3 out1 unexpected", out1_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp1.pop_front();
        chk(out1_data == e, "R3 out1 word", out1_data, e);
      end
    end
  end

  task automatic send(int p, logic [DW-1:0] w);
    int n;
    @(posedge clk); #2;
    if (p == 0) begin in0_valid = 1; in0_data = w; end
    else begin in1_valid = 1; in1_data = w; end
    n = 0;
    forever begin
      @(negedge clk);
      if ((p == 0 ? in0_ready : in1_ready)) break;
      n++;
      if (n > 50) begin chk(0, "R3 send hung", 0, 1); break; end
    end
    note(w);
    @(posedge clk); #2;
    if (p == 0) in0_valid = 0; else in1_valid = 0;
  endtask

  initial begin
    #100000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk(!out0_valid && !out1_valid && drop_count == 0, "R1 in reset", drop_count, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!out0_valid && !out1_valid && drop_count == 0, "R1 after reset", {out1_valid, out0_valid}, 0);

    // R6 R7: contention, input 1 first, then alternating
    @(posedge clk); #2;
    in0_valid = 1; in0_data = 32'h0000_1000;
    in1_valid = 1; in1_data = 32'h0000_2001;
    @(negedge clk);
    chk(in1_ready && !in0_ready, "R6 first winner", {in1_ready, in0_ready}, 2'b10);
    note(in1_data);
    @(posedge clk); #2 in1_data = 32'h0000_2003;
    @(negedge clk);
    chk(in0_ready && !in1_ready, "R7 second winner", {in1_ready, in0_ready}, 2'b01);
    note(in0_data);
    @(posedge clk); #2 in0_data = 32'h0000_1002;
    @(negedge clk);
    chk(in1_ready && !in0_ready, "R7 third winner", {in1_ready, in0_ready}, 2'b10);
    note(in1_data);
    @(posedge clk); #2 in1_valid = 0;
    @(negedge clk);
    chk(in0_ready, "R6 lone input served", in0_ready, 1);
    note(in0_data);
    @(posedge clk); #2 in0_valid = 0;

    // R3 varied patterns
    send(0, 32'h1234_5678);
    send(1, 32'h7FFF_FFFF);
    send(1, 32'h0ABC_DEF0);
    send(0, 32'h0000_0001);

    // R2 single discard
    send(0, 32'h8000_0000);
    chk(drop_count == exp_cnt, "R2 count +1", drop_count, exp_cnt);
    send(1, 32'hFFFF_FFFF);
    chk(drop_count == exp_cnt, "R2 count +1 in1", drop_count, exp_cnt);

    // R4 double discard
    @(posedge clk); #2;
    in0_valid = 1; in0_data = 32'h8000_0010;
    in1_valid = 1; in1_data = 32'h8000_0011;
    @(negedge clk);
    chk(in0_ready && in1_ready, "R4 both popped", {in1_ready, in0_ready}, 2'b11);
    note(in0_data); note(in1_data);
    @(posedge clk); #2 in0_valid = 0; in1_valid = 0;
    chk(drop_count == exp_cnt, "R4 count +2", drop_count, exp_cnt);

    // R8 R9 stall on output 0
    @(posedge clk); #2 out0_ready = 0;
    send(0, 32'h0000_0AA0);
    @(posedge clk); #2;
    in0_valid = 1; in0_data = 32'h0000_0BB0;
    in1_valid = 1; in1_data = 32'h8000_0CC0;
    @(negedge clk);
    chk(!in0_ready, "R8 blocked by full output", in0_ready, 0);
    chk(in1_ready, "R9 discard during stall", in1_ready, 1);
    note(in1_data);
    @(posedge clk); #2 in1_valid = 0;
    repeat (2) @(negedge clk);
    chk(!in0_ready, "R8 still blocked", in0_ready, 0);
    chk(out0_valid && out0_data == 32'h0000_0AA0, "R8 held word", out0_data, 32'h0000_0AA0);
    @(posedge clk); #2 out0_ready = 1;
    @(negedge clk);
    chk(in0_ready, "R8 accepted when drained", in0_ready, 1);
    note(in0_data);
    @(posedge clk); #2 in0_valid = 0;
    chk(drop_count == exp_cnt, "R9 count", drop_count, exp_cnt);

    // R5 saturation
    @(posedge clk); #2;
    in0_valid = 1; in0_data = 32'h8000_0000;
    in1_valid = 1; in1_data = 32'h8000_0001;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      note(in0_data); note(in1_data);
    end
    @(posedge clk); #2 in0_valid = 0; in1_valid = 0;
    chk(drop_count == CMAX && exp_cnt == CMAX, "R5 saturated", drop_count, CMAX);
    send(0, 32'hC000_0000);
    chk(drop_count == CMAX, "R5 holds at max", drop_count, CMAX);

    repeat (5) @(negedge clk);
    chk(exp0.size() == 0 && exp1.size() == 0, "R3 all delivered", exp0.size() + exp1.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule